// File: doc/BRIEF.md
# Serial Pixel Parameter Unpacker

This block sits behind the bit-level receiver of a serial display command port. Each incoming 9-bit word carries a flag in its top bit: a 1 marks a parameter byte, a 0 marks a command byte. When a memory-write or memory-write-continue command opens a data run, the parameter bytes that follow are grouped into pixels and widened to 18-bit RGB666. The widened pixels go out as a valid/data stream to a display RAM address generator.

Three packings are understood: 12-bit colour (two pixels in three bytes), 16-bit colour (one pixel in two bytes, with an optional byte-order swap) and 18-bit colour (one pixel in three bytes). The low bits of the narrow formats are filled by a selectable rule. A memory-write command also sends a one-cycle pulse telling the address generator to return to the start of its window. The continue command keeps the current position. Any command ends the pixel that is being assembled.

Top module: `spx_unpack`

## Requirements
- R1: After reset, `pix_valid_o` and `ptr_reset_o` are 0, `pix_o` is 0, and no data run is open. Parameter words are ignored until a write command arrives.
- R2: A pixel comes only from a parameter word (bit 8 = 1) that arrives while a data run is open. A run opens on command code `WR_CODE` (default 8'h2C) or `CONT_CODE` (default 8'h3C). Parameter words outside a run produce no pixel.
- R3: Any command word (bit 8 = 0) throws away a partly assembled pixel and returns the byte phase to the first byte. A command whose code is neither write code closes the run.
- R4: `ptr_reset_o` pulses for one cycle, in the cycle after a `WR_CODE` command is accepted. `CONT_CODE` reopens the run without that pulse.
- R5: With `fmt_i` = 0 (12-bit), three bytes carry two pixels. Byte 1 holds R1 in [7:4] and G1 in [3:0]. Byte 2 holds B1 in [7:4] and R2 in [3:0]. Byte 3 holds G2 in [7:4] and B2 in [3:0]. Pixel 1 is emitted on byte 2 and pixel 2 on byte 3.
- R6: With `fmt_i` = 1 (16-bit) and `swap_i` = 0, the first byte is RRRRRGGG and the second byte is GGGBBBBB. With `swap_i` = 1, the two bytes arrive in the reverse order. The pixel is emitted on the second byte.
- R7: With `fmt_i` = 2 (18-bit), bytes 1, 2 and 3 carry R, G and B in bits [7:2]. Bits [1:0] are ignored. The pixel is emitted on the third byte.
- R8: Each channel narrower than 6 bits is left-aligned. Its low bits are then filled according to `fill_i`: 0 gives zeros, 1 gives ones, 2 copies the channel's top bits (MSB first), and 3 behaves as 0.
- R9: `pix_o` = {R[5:0], G[5:0], B[5:0]} (R at [17:12]). The pixel appears registered, with `pix_valid_o` high for one cycle, in the cycle after the word that completes it.
- R10: With `fmt_i` = 3 (reserved), parameter words produce no pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_valid_i | input | 1 | Word strobe, one cycle per received word |
| word_i | input | 9 | Bit 8 is the parameter flag; [7:0] is the payload |
| fmt_i | input | 2 | Pixel packing: 0 = 12-bit, 1 = 16-bit, 2 = 18-bit, 3 = reserved |
| fill_i | input | 2 | Low-bit fill rule for narrow channels |
| swap_i | input | 1 | Byte-order swap for the 16-bit format |
| pix_valid_o | output | 1 | One-cycle pixel strobe |
| pix_o | output | 18 | RGB666 pixel |
| ptr_reset_o | output | 1 | Pulse that returns the address generator to the window start |

## Verification
On every cycle, the assertions check that:
- each pixel strobe follows a parameter word and never a command word;
- the pointer pulse follows only a memory-write command;
- an unrelated command closes the run;
- an abort puts the byte phase back to zero;
- the phase never takes its unused value;
- the reserved format emits nothing.

Only the directed scenarios can show that the bits are placed correctly for each packing, that the byte swap and the three fill rules work, that the 12-bit nibbles straddle byte boundaries as required, and that an aborted pixel leaves no stale bytes in the next one.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;
  localparam int CH_W   = 6;
  localparam int PIX_W  = 3 * CH_W;

  typedef enum logic [1:0] {FMT_12 = 2'd0, FMT_16 = 2'd1, FMT_18 = 2'd2, FMT_RSV = 2'd3} fmt_e;
  typedef enum logic [1:0] {FILL_ZERO = 2'd0, FILL_ONE = 2'd1, FILL_MSB = 2'd2, FILL_RSV = 2'd3} fill_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pix_t;

  // significant width of a channel (0=r,1=g,2=b) for a packing
  function automatic int ch_width(input fmt_e fmt, input int ch);
    case (fmt)
      FMT_12:  return 4;
      FMT_16:  return (ch == 1) ? 6 : 5;
      default: return CH_W;
    endcase
  endfunction

  // v is left-aligned with w significant bits; fill the rest
  function automatic logic [CH_W-1:0] fill_low(input logic [CH_W-1:0] v, input int w,
                                               input fill_e mode);
    logic [CH_W-1:0] o;
    o = v;
    for (int i = 0; i < CH_W; i++) begin
      if (i < CH_W - w) begin
        case (mode)
          FILL_ONE: o[i] = 1'b1;
          FILL_MSB: o[i] = v[w + i];
          default:  o[i] = 1'b0;
        endcase
      end
    end
    return o;
  endfunction
endpackage

// File: rtl/spx_cmd_track.sv
module spx_cmd_track
  import spx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_CODE   = 8'h2C,
  parameter logic [BYTE_W-1:0] CONT_CODE = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  output logic              abort_o,
  output logic              ptr_reset_o
);
  localparam int FLAG = WORD_W - 1;

  logic run_q, ptr_q;
  logic is_wr, is_cont;

  assign abort_o = word_valid_i && !word_i[FLAG];
  assign is_wr   = abort_o && (word_i[BYTE_W-1:0] == WR_CODE);
  assign is_cont = abort_o && (word_i[BYTE_W-1:0] == CONT_CODE);
  assign take_o  = word_valid_i && word_i[FLAG] && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ptr_q <= 1'b0;
    end else begin
      ptr_q <= is_wr;
      if (abort_o) run_q <= is_wr || is_cont;
    end
  end

  assign ptr_reset_o = ptr_q;

  assert_ptr_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_reset_o |-> $past(word_valid_i && !word_i[FLAG] && word_i[BYTE_W-1:0] == WR_CODE));

  assert_run_close_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !word_i[FLAG] && word_i[BYTE_W-1:0] != WR_CODE &&
     word_i[BYTE_W-1:0] != CONT_CODE) |=> !take_o);
endmodule

// File: rtl/spx_assemble.sv
module spx_assemble
  import spx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              abort_i,
  input  fmt_e              fmt_i,
  input  logic              swap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              emit_o,
  output pix_t              raw_o
);
  logic [1:0]        phase_q, last_idx;
  logic [BYTE_W-1:0] h0_q, h1_q;
  logic [BYTE_W-1:0] hi, lo;

  always_comb begin
    case (fmt_i)
      FMT_16:  last_idx = 2'd1;
      default: last_idx = 2'd2;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      h0_q    <= '0;
      h1_q    <= '0;
    end else if (abort_i) begin
      phase_q <= '0;
    end else if (take_i) begin
      phase_q <= (phase_q >= last_idx) ? 2'd0 : phase_q + 2'd1;
      if (phase_q == 2'd0) h0_q <= byte_i;
      if (phase_q == 2'd1) h1_q <= byte_i;
    end
  end

  assign hi = swap_i ? byte_i : h0_q;
  assign lo = swap_i ? h0_q : byte_i;

  // channels left-aligned; expander fills the low bits
  always_comb begin
    emit_o = 1'b0;
    raw_o  = '0;
    if (take_i) begin
      case (fmt_i)
        FMT_12: begin
          if (phase_q == 2'd1) begin
            emit_o = 1'b1;
            raw_o.r = {h0_q[7:4], 2'b00};
            raw_o.g = {h0_q[3:0], 2'b00};
            raw_o.b = {byte_i[7:4], 2'b00};
          end else if (phase_q == 2'd2) begin
            emit_o = 1'b1;
            raw_o.r = {h1_q[3:0], 2'b00};
            raw_o.g = {byte_i[7:4], 2'b00};
            raw_o.b = {byte_i[3:0], 2'b00};
          end
        end
        FMT_16: begin
          if (phase_q == 2'd1) begin
            emit_o = 1'b1;
            raw_o.r = {hi[7:3], 1'b0};
            raw_o.g = {hi[2:0], lo[7:5]};
            raw_o.b = {lo[4:0], 1'b0};
          end
        end
        FMT_18: begin
          if (phase_q == 2'd2) begin
            emit_o = 1'b1;
            raw_o.r = h0_q[7:2];
            raw_o.g = h1_q[7:2];
            raw_o.b = byte_i[7:2];
          end
        end
        default: ;
      endcase
    end
  end

  assert_phase_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);

  assert_abort_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> phase_q == 2'd0);
endmodule

// File: rtl/spx_expand.sv
module spx_expand
  import spx_pkg::*;
(
  input  fmt_e  fmt_i,
  input  fill_e fill_i,
  input  pix_t  raw_i,
  output pix_t  pix_o
);
  logic [CH_W-1:0] ch_in  [3];
  logic [CH_W-1:0] ch_out [3];

  assign ch_in[0] = raw_i.r;
  assign ch_in[1] = raw_i.g;
  assign ch_in[2] = raw_i.b;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign ch_out[c] = fill_low(ch_in[c], ch_width(fmt_i, c), fill_i);
  end

  assign pix_o = '{r: ch_out[0], g: ch_out[1], b: ch_out[2]};
endmodule

// File: rtl/spx_unpack.sv
module spx_unpack
  import spx_pkg::*;
#(
  parameter logic [7:0] WR_CODE   = 8'h2C,
  parameter logic [7:0] CONT_CODE = 8'h3C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        word_valid_i,
  input  logic [8:0]  word_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  fill_i,
  input  logic        swap_i,
  output logic        pix_valid_o,
  output logic [17:0] pix_o,
  output logic        ptr_reset_o
);
  logic take, abort, emit;
  pix_t raw, wide;
  logic             valid_q;
  logic [PIX_W-1:0] pix_q;

  spx_cmd_track #(.WR_CODE(WR_CODE), .CONT_CODE(CONT_CODE)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_valid_i(word_valid_i),
    .word_i      (word_i),
    .take_o      (take),
    .abort_o     (abort),
    .ptr_reset_o (ptr_reset_o)
  );

  spx_assemble u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .abort_i(abort),
    .fmt_i  (fmt_e'(fmt_i)),
    .swap_i (swap_i),
    .byte_i (word_i[BYTE_W-1:0]),
    .emit_o (emit),
    .raw_o  (raw)
  );

  spx_expand u_exp (
    .fmt_i (fmt_e'(fmt_i)),
    .fill_i(fill_e'(fill_i)),
    .raw_i (raw),
    .pix_o (wide)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= emit;
      if (emit) pix_q <= wide;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_o       = pix_q;

  assert_pix_from_param_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(word_valid_i && word_i[8]));

  assert_cmd_no_pix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !word_i[8]) |=> !pix_valid_o);

  assert_rsv_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(fmt_i != 2'd3));
endmodule

// File: tb/spx_unpack_tb.sv
module spx_unpack_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [8:0]  word_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [1:0]  fill_i = '0;
  logic        swap_i = 1'b0;
  logic        pix_valid_o, ptr_reset_o;
  logic [17:0] pix_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic        got_pv, got_pr;
  logic [17:0] got_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  spx_unpack dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .word_valid_i(word_valid_i), .word_i(word_i),
    .fmt_i(fmt_i), .fill_i(fill_i), .swap_i(swap_i),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o), .ptr_reset_o(ptr_reset_o)
  );

  function automatic [5:0] ex(input int w, input [5:0] v, input [1:0] f);
    case (w)
      4: return {v[3:0], (f == 2'd1) ? 2'b11 : (f == 2'd2) ? v[3:2] : 2'b00};
      5: return {v[4:0], (f == 2'd1) ? 1'b1 : (f == 2'd2) ? v[4] : 1'b0};
      default: return v;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] w);
    @(negedge clk);
    word_valid_i = 1'b1;
    word_i = w;
    @(posedge clk);
    #1;
    got_pv = pix_valid_o; got_pix = pix_o; got_pr = ptr_reset_o;
    word_valid_i = 1'b0;
  endtask

  function automatic [8:0] prm(input [7:0] b); return {1'b1, b}; endfunction
  function automatic [8:0] cmd(input [7:0] c); return {1'b0, c}; endfunction

  task automatic setup(input [1:0] f, input [1:0] fl, input s);
    @(negedge clk);
    fmt_i = f; fill_i = fl; swap_i = s;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", pix_valid_o, 0);
    chk("R1 ptr", ptr_reset_o, 0);
    chk("R1 pix", pix_o, 0);
    rst_ni = 1'b1;
    setup(2'd1, 2'd0, 1'b0);
    send(prm(8'hFF)); chk("R1 idle param", got_pv, 0);
    send(prm(8'hFF)); chk("R1 idle param2", got_pv, 0);
  endtask

  task automatic t_fmt12(input [1:0] fl);
    setup(2'd0, fl, 1'b0);
    send(cmd(8'h2C)); chk("R4 wr ptr pulse", got_pr, 1); chk("R2 no pix on cmd", got_pv, 0);
    send(prm(8'hA5)); chk("R5 byte1 none", got_pv, 0); chk("R4 ptr one cycle", got_pr, 0);
    send(prm(8'h3C)); chk("R5 pix1 valid", got_pv, 1);
    chk("R5 R8 R9 pix1", got_pix, {ex(4, 6'hA, fl), ex(4, 6'h5, fl), ex(4, 6'h3, fl)});
    send(prm(8'h96)); chk("R5 pix2 valid", got_pv, 1);
    chk("R5 R8 pix2", got_pix, {ex(4, 6'hC, fl), ex(4, 6'h9, fl), ex(4, 6'h6, fl)});
    @(posedge clk); #1; chk("R9 one-cycle strobe", pix_valid_o, 0);
  endtask

  task automatic t_fmt16(input s, input [1:0] fl);
    setup(2'd1, fl, s);
    send(cmd(8'h2C));
    send(prm(s ? 8'h5A : 8'hB3)); chk("R6 byte1 none", got_pv, 0);
    send(prm(s ? 8'hB3 : 8'h5A)); chk("R6 valid", got_pv, 1);
    chk(s ? "R6 swap R8 pix" : "R6 R8 pix", got_pix,
        {ex(5, 6'h16, fl), 6'h1A, ex(5, 6'h1A, fl)});
  endtask

  task automatic t_fmt18;
    setup(2'd2, 2'd1, 1'b0);
    send(cmd(8'h2C));
    send(prm(8'hFF)); chk("R7 b1 none", got_pv, 0);
    send(prm(8'h81)); chk("R7 b2 none", got_pv, 0);
    send(prm(8'h42)); chk("R7 valid", got_pv, 1);
    chk("R7 pix low bits ignored", got_pix, {6'h3F, 6'h20, 6'h10});
  endtask

  task automatic t_abort_continue;
    setup(2'd1, 2'd0, 1'b0);
    send(cmd(8'h2C));
    send(prm(8'hFF));
    send(cmd(8'h3C)); chk("R3 abort no pix", got_pv, 0); chk("R4 cont no ptr", got_pr, 0);
    send(prm(8'hB3)); chk("R3 phase reset", got_pv, 0);
    send(prm(8'h5A)); chk("R3 fresh pix valid", got_pv, 1);
    chk("R3 fresh pix", got_pix, {6'h2C, 6'h1A, 6'h34});
    send(cmd(8'h00)); chk("R3 nop no ptr", got_pr, 0);
    send(prm(8'h11)); send(prm(8'h22)); chk("R3 closed run ignored", got_pv, 0);
    send(prm(8'h33)); chk("R3 closed run ignored2", got_pv, 0);
    chk("R3 pix held", pix_o, {6'h2C, 6'h1A, 6'h34});
  endtask

  task automatic t_reserved;
    setup(2'd3, 2'd0, 1'b0);
    send(cmd(8'h2C));
    for (int i = 0; i < 4; i++) begin
      send(prm(8'h77)); chk("R10 reserved silent", got_pv, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_fmt12(2'd0);
    t_fmt12(2'd1);
    t_fmt12(2'd2);
    t_fmt12(2'd3);
    t_fmt16(1'b0, 2'd0);
    t_fmt16(1'b1, 2'd1);
    t_fmt16(1'b0, 2'd2);
    t_fmt18;
    t_abort_continue;
    t_reserved;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule